// File: doc/BRIEF.md
# Serial Channel Error Flag Unit

This block keeps the error status of one serial channel. The channel runs in one of two ways. It can be an asynchronous UART. It can also be a clocked synchronous shift link, where the transfer clock comes either from outside the chip or from the chip itself. The receive and transmit datapaths send per-cycle strobes to the block. The block turns those strobes into three sticky flags: overrun, parity and framing.

In synchronous mode with an external clock, the parity flag is reused to report a transmit underrun. A single read strobe from the status register clears all three flags. The current mode decides which flags can be raised at all. A flag that cannot occur in the current mode reads 0, and its stored state is dropped.

The block also holds the synchronous bit-order setting (MSB first or LSB first). A write to that setting is not applied while a transfer is in progress. It waits until the transfer ends.

Top module: `serial_err_flags`

## Requirements
- R1: In UART mode (mode 2'b00) and in external-clock synchronous mode (mode 2'b01), the overrun flag is set when a frame-complete strobe arrives while the receive buffer is still full.
- R2: A status-read strobe with no new error in the same cycle clears all three flags on the next clock edge.
- R3: In UART mode with parity enabled, the parity flag is set when a frame completes and the received parity bit differs from the XOR of the data bits XOR the parity-type bit (0 = even, 1 = odd).
- R4: In UART mode, the framing flag is set when a frame completes with a sampled stop bit of 0.
- R5: In external-clock synchronous mode with the double buffer enabled, the parity flag acts as underrun. It is set on a transfer clock edge that arrives while both the transmit shift register and the transmit buffer are empty.
- R6: In external-clock synchronous mode with the double buffer disabled, the parity flag reads 0 and its stored value is discarded.
- R7: In both synchronous modes, the framing flag reads 0 and is never set.
- R8: In internal-clock synchronous mode (mode 2'b10; 2'b11 behaves the same), all three flags read 0 whatever the strobes are.
- R9: A bit-order write (1 = MSB first) made while busy is low takes effect on the next edge. A write made while busy is high is held. It is applied on the first edge at which busy is low.
- R10: An error that occurs in the same cycle as a status read leaves its flag set.
- R11: In UART mode with parity disabled, a parity mismatch does not set the parity flag.
- R12: After reset, all flags are 0 and the bit order is LSB first (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 UART, 01 sync external clock, 10/11 sync internal clock |
| dbuf_en_i | input | 1 | Transmit double buffer enable |
| par_en_i | input | 1 | UART parity enable |
| par_odd_i | input | 1 | Parity type: 0 even, 1 odd |
| rx_done_i | input | 1 | Frame fully received (strobe) |
| rx_full_i | input | 1 | Receive buffer still holds unread data |
| rx_xor_i | input | 1 | XOR of received data bits |
| rx_pbit_i | input | 1 | Received parity bit |
| rx_stop_i | input | 1 | Stop bit sampled at mid-bit |
| tx_sh_empty_i | input | 1 | Transmit shift register empty |
| tx_buf_empty_i | input | 1 | Transmit buffer empty |
| sclk_edge_i | input | 1 | Transfer clock edge (strobe) |
| stat_rd_i | input | 1 | Status register read (clears flags) |
| busy_i | input | 1 | Transfer in progress |
| ord_wr_i | input | 1 | Bit-order write strobe |
| ord_val_i | input | 1 | Bit-order write value |
| ovr_o | output | 1 | Overrun flag |
| par_o | output | 1 | Parity / underrun flag |
| frm_o | output | 1 | Framing flag |
| msb_first_o | output | 1 | Active bit order |

## Verification
The bench targets several corner cases.

- **Read and error in the same cycle.** A design that let the clear win would lose the new framing error.
- **Odd parity.** The bench uses odd parity with a correct parity bit and then with a wrong one. A design that ignored the parity type would flag the wrong frame of the pair.
- **Mode masking.** The bench raises flags and then switches modes or turns off the double buffer. It checks that they read 0 and stay 0 after the mode returns. A design that only masked the output would bring the stale error back.
- **Bit-order writes during a transfer.** A design that applied the write at once would change bit order in mid-transfer.
- **Underrun with a transmit buffer that is not empty.** The bench checks that this case does not raise underrun.

// File: rtl/serr_pkg.sv
package serr_pkg;
   typedef enum logic [1:0] {
      SERR_UART     = 2'b00,
      SERR_SYNC_EXT = 2'b01,
      SERR_SYNC_INT = 2'b10,
      SERR_SYNC_ALT = 2'b11
   } serr_mode_e;

   localparam int unsigned SERR_NFLAG = 3;
   localparam int unsigned SERR_OVR   = 0;
   localparam int unsigned SERR_PAR   = 1;
   localparam int unsigned SERR_FRM   = 2;
endpackage

// File: rtl/serr_flag_cell.sv
module serr_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic allow_i,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic q_r;
   logic q_nxt;

   generate
      if (SET_WINS) begin : g_set_wins
         assign q_nxt = allow_i & (set_i | (q_r & ~clr_i));
      end else begin : g_clr_wins
         assign q_nxt = allow_i & ~clr_i & (set_i | q_r);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= q_nxt;
   end

   assign flag_o = q_r & allow_i;

   // R2
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_r);

   generate
      if (SET_WINS) begin : g_keep_chk
         // R10
         set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (allow_i && set_i) |=> q_r);
      end
   endgenerate
endmodule

// File: rtl/serr_order_ctl.sv
module serr_order_ctl #(
   parameter bit ORDER_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic wr_i,
   input  logic val_i,
   output logic msb_o
);
   logic pend_v_r;
   logic pend_d_r;
   logic msb_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v_r <= 1'b0;
         pend_d_r <= 1'b0;
         msb_r    <= ORDER_RESET;
      end else if (!busy_i) begin
         pend_v_r <= 1'b0;
         if (wr_i)          msb_r <= val_i;
         else if (pend_v_r) msb_r <= pend_d_r;
      end else if (wr_i) begin
         pend_v_r <= 1'b1;
         pend_d_r <= val_i;
      end
   end

   assign msb_o = msb_r;

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(msb_o));

   // R9
   idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && wr_i) |=> (msb_o == $past(val_i)));
endmodule

// File: rtl/serial_err_flags.sv
module serial_err_flags
   import serr_pkg::*;
#(
   parameter bit ORDER_RESET = 1'b0,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       dbuf_en_i,
   input  logic       par_en_i,
   input  logic       par_odd_i,
   input  logic       rx_done_i,
   input  logic       rx_full_i,
   input  logic       rx_xor_i,
   input  logic       rx_pbit_i,
   input  logic       rx_stop_i,
   input  logic       tx_sh_empty_i,
   input  logic       tx_buf_empty_i,
   input  logic       sclk_edge_i,
   input  logic       stat_rd_i,
   input  logic       busy_i,
   input  logic       ord_wr_i,
   input  logic       ord_val_i,
   output logic       ovr_o,
   output logic       par_o,
   output logic       frm_o,
   output logic       msb_first_o
);
   generate
      if ($bits(serr_mode_e) != 2) begin : g_bad_mode
         $error("serial_err_flags: mode encoding must be 2 bits");
      end
   endgenerate

   serr_mode_e mode;
   logic is_uart, is_ext;
   logic [SERR_NFLAG-1:0] allow, set, flag;

   assign mode    = serr_mode_e'(mode_i);
   assign is_uart = (mode == SERR_UART);
   assign is_ext  = (mode == SERR_SYNC_EXT);

   always_comb begin
      allow[SERR_OVR] = is_uart | is_ext;
      allow[SERR_PAR] = is_uart | (is_ext & dbuf_en_i);
      allow[SERR_FRM] = is_uart;

      set[SERR_OVR] = rx_done_i & rx_full_i;
      if (is_uart)
         set[SERR_PAR] = rx_done_i & par_en_i & (rx_pbit_i != (rx_xor_i ^ par_odd_i));
      else
         set[SERR_PAR] = sclk_edge_i & tx_sh_empty_i & tx_buf_empty_i;
      set[SERR_FRM] = rx_done_i & ~rx_stop_i;
   end

   genvar gi;
   generate
      for (gi = 0; gi < SERR_NFLAG; gi++) begin : g_flag
         serr_flag_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .allow_i (allow[gi]),
            .set_i   (set[gi]),
            .clr_i   (stat_rd_i),
            .flag_o  (flag[gi])
         );
      end
   endgenerate

   assign ovr_o = flag[SERR_OVR];
   assign par_o = flag[SERR_PAR];
   assign frm_o = flag[SERR_FRM];

   serr_order_ctl #(.ORDER_RESET(ORDER_RESET)) u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_i),
      .wr_i   (ord_wr_i),
      .val_i  (ord_val_i),
      .msb_o  (msb_first_o)
   );

   // R7
   frm_sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b00) |-> !frm_o);

   // R8
   int_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i[1] |-> !(ovr_o | par_o | frm_o));

   // R6
   no_dbuf_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 && !dbuf_en_i) |-> !par_o);

   // R4
   frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 && $past(mode_i) == 2'b00 && rx_done_i && !rx_stop_i) |=>
         (frm_o || mode_i != 2'b00));
endmodule

// File: tb/test_serial_err_flags.sv
module test_serial_err_flags;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode;
   logic dbuf, pen, podd, done, full, xr, pbit, stop, txs, txb, edg, rd;
   logic busy, owr, oval;
   logic ovr, par, frm, msb;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   serial_err_flags i_serial_err_flags (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .dbuf_en_i(dbuf),
      .par_en_i(pen), .par_odd_i(podd), .rx_done_i(done), .rx_full_i(full),
      .rx_xor_i(xr), .rx_pbit_i(pbit), .rx_stop_i(stop),
      .tx_sh_empty_i(txs), .tx_buf_empty_i(txb), .sclk_edge_i(edg),
      .stat_rd_i(rd), .busy_i(busy), .ord_wr_i(owr), .ord_val_i(oval),
      .ovr_o(ovr), .par_o(par), .frm_o(frm), .msb_first_o(msb)
   );

   // fields: mode(2) dbuf pen podd done full xor pbit stop txs txb edg rd | ovr par frm
   localparam int NV = 20;
   localparam logic [16:0] VEC [NV] = '{
      {2'b00, 12'b0_1_0_1_0_0_0_1_0_0_0_0, 3'b000},
      {2'b00, 12'b0_1_0_1_1_0_0_1_0_0_0_0, 3'b100},
      {2'b00, 12'b0_1_0_0_0_0_0_1_0_0_0_1, 3'b000},
      {2'b00, 12'b0_1_0_1_0_1_0_1_0_0_0_0, 3'b010},
      {2'b00, 12'b0_1_1_1_0_1_0_1_0_0_0_0, 3'b010},
      {2'b00, 12'b0_1_1_0_0_0_0_1_0_0_0_1, 3'b000},
      {2'b00, 12'b0_1_1_1_0_0_0_1_0_0_0_0, 3'b010},
      {2'b00, 12'b0_1_0_1_0_0_0_0_0_0_0_1, 3'b001},
      {2'b00, 12'b0_0_0_1_0_1_0_1_0_0_0_0, 3'b001},
      {2'b00, 12'b0_0_0_0_0_0_0_1_0_0_0_1, 3'b000},
      {2'b01, 12'b1_0_0_0_0_0_0_1_1_1_1_0, 3'b010},
      {2'b01, 12'b1_0_0_1_1_0_0_0_0_0_0_0, 3'b110},
      {2'b01, 12'b1_0_0_0_0_0_0_1_0_0_0_1, 3'b000},
      {2'b01, 12'b0_0_0_0_0_0_0_1_1_1_1_0, 3'b000},
      {2'b01, 12'b1_0_0_0_0_0_0_1_1_0_1_0, 3'b000},
      {2'b10, 12'b1_1_0_1_1_1_0_0_1_1_1_0, 3'b000},
      {2'b00, 12'b0_0_0_0_0_0_0_1_0_0_0_0, 3'b000},
      {2'b01, 12'b1_0_0_0_0_0_0_1_1_1_1_0, 3'b010},
      {2'b01, 12'b0_0_0_0_0_0_0_1_0_0_0_0, 3'b000},
      {2'b01, 12'b1_0_0_0_0_0_0_1_0_0_0_0, 3'b000}
   };
   // requirement covered by each vector row
   localparam string VREQ [NV] = '{
      "R3", "R1", "R2", "R3", "R3", "R2", "R3", "R4/R10", "R11", "R2",
      "R5", "R1/R7", "R2", "R6", "R5", "R8", "R8", "R5", "R6", "R6"
   };

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic idle();
      mode = 2'b00; dbuf = 0; pen = 0; podd = 0; done = 0; full = 0;
      xr = 0; pbit = 0; stop = 1; txs = 0; txb = 0; edg = 0; rd = 0;
      busy = 0; owr = 0; oval = 0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12", {ovr, par, frm, msb}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", {ovr, par, frm, msb}, 4'b0000);

      for (int i = 0; i < NV; i++) begin
         {mode, dbuf, pen, podd, done, full, xr, pbit, stop, txs, txb, edg, rd} = VEC[i][16:3];
         @(negedge clk);
         chk(VREQ[i], {1'b0, ovr, par, frm}, {1'b0, VEC[i][2:0]});
      end

      // R9 idle write applies next edge
      idle();
      owr = 1; oval = 1;
      @(negedge clk);
      chk("R9", {3'b000, msb}, 4'b0001);
      // R9 write during busy is held
      busy = 1; owr = 1; oval = 0;
      @(negedge clk);
      owr = 0;
      chk("R9", {3'b000, msb}, 4'b0001);
      @(negedge clk);
      chk("R9", {3'b000, msb}, 4'b0001);
      busy = 0;
      @(negedge clk);
      chk("R9", {3'b000, msb}, 4'b0000);
      // R9 idle write overrides an older pending value
      busy = 1; owr = 1; oval = 1;
      @(negedge clk);
      busy = 0; owr = 1; oval = 0;
      @(negedge clk);
      owr = 0;
      chk("R9", {3'b000, msb}, 4'b0000);
      @(negedge clk);
      chk("R9", {3'b000, msb}, 4'b0000);

      // R10 overrun and read together in UART
      done = 1; full = 1; rd = 1;
      @(negedge clk);
      done = 0; full = 0; rd = 0;
      chk("R10", {1'b0, ovr, par, frm}, 4'b0100);

      // R12 reset mid-run clears flags and bit order
      owr = 1; oval = 1;
      @(negedge clk);
      owr = 0;
      rst_n = 1'b0;
      #1;
      chk("R12", {ovr, par, frm, msb}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule